// File: doc/BRIEF.md
# Loopback Round-Trip Latency Timer

The block sits between an inbound word stream coming back from an external host and an outbound word stream going to the host. In normal operation every valid inbound word is copied to the outbound stream one clock later, so the host's traffic makes a closed loop through the block. Before a measurement the host keeps that loop busy with a constant fill word.

To take a measurement, the host pulses the arm input. From the next clock the block replaces every echoed word with a configurable marker word and starts a cycle counter at zero. The counter stops on the first valid inbound word that equals the marker and differs from the fill word. At a 250 MHz clock, one count is 4 ns, so the held count gives the round-trip time directly. If the marker never returns, the counter saturates and a timeout flag is raised instead. Pulsing arm again clears the result and starts a new measurement.

Top module: `lbt_latency_timer`

## Requirements
- R1: While reset is asserted and after its release with no other stimulus, out_valid_o, out_data_o, busy_o, done_o, timeout_o and count_o are all zero.
- R2: While busy_o is low, out_valid_o equals in_valid_i of the previous cycle. When that word was valid, out_data_o equals its in_data_i. Otherwise out_data_o holds its last value.
- R3: One cycle after arm_i is sampled high, busy_o is 1, count_o is 0, and done_o and timeout_o are 0. arm_i takes priority over every other event in that cycle.
- R4: While busy_o is high, each valid inbound word makes out_valid_o high one cycle later, with out_data_o equal to marker_i in place of the inbound data.
- R5: While busy_o is high and no stop or timeout occurs, count_o rises by exactly one per clock.
- R6: When busy_o is high and a valid inbound word equals marker_i and differs from fill_i, the next cycle shows busy_o 0, done_o 1 and count_o one above its previous value. The count then holds until the next arm.
- R7: Inbound words equal to fill_i, words differing from marker_i, words with in_valid_i low, and words arriving while busy_o is low never set done_o.
- R8: When count_o is at its all-ones value while busy_o is high and no stop occurs, the next cycle shows busy_o 0, timeout_o 1, done_o 0, and count_o stays all-ones until the next arm.
- R9: An arm pulse while busy, after done or after timeout restarts the measurement from zero exactly as in R3.
- R10: done_o and timeout_o are never high together, and neither is high while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Single-cycle pulse that starts or restarts a measurement |
| fill_i | input | DW | Constant fill word carried by the loop when idle |
| marker_i | input | DW | Word injected while measuring and detected on return |
| in_valid_i | input | 1 | Inbound word valid |
| in_data_i | input | DW | Inbound word |
| out_valid_o | output | 1 | Outbound word valid |
| out_data_o | output | DW | Outbound word (echo or marker) |
| busy_o | output | 1 | Measurement running |
| done_o | output | 1 | Marker returned, count valid |
| timeout_o | output | 1 | Counter saturated before the marker returned |
| count_o | output | CW | Cycle count from arm to marker return |

## Verification
Idle traffic carries changing words, including the marker value itself, with gaps in the valid stream. This separates a correct echo from one that injects too early and from a detector that is not gated by arming. Closed-loop runs through a modelled return path use two different delays, one with a continuous valid stream and one with gaps. The expected count comes from the delay, which exposes off-by-one errors in the start and stop edges. A run carrying only non-marker words, and a run where the marker equals the fill word, must both end in saturation rather than a false stop. Re-arming while running and after completion shows that the earlier result is fully cleared.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2,
    ST_TOUT = 2'd3
  } lbt_state_e;
endpackage

// File: rtl/lbt_match_detect.sv
module lbt_match_detect #(
  parameter int DW = 32
) (
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] marker_i,
  input  logic [DW-1:0] fill_i,
  output logic          hit_o
);
  logic is_marker;
  logic is_fill;

  always_comb begin
    is_marker = (data_i == marker_i);
    is_fill   = (data_i == fill_i);
    hit_o     = valid_i && is_marker && !is_fill;
  end
endmodule

// File: rtl/lbt_echo_path.sv
module lbt_echo_path #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          inject_i,
  input  logic [DW-1:0] marker_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o
);
  logic          vld_q;
  logic [DW-1:0] dat_q;
  logic [DW-1:0] dat_n;
  logic          dat_en;

  always_comb begin
    dat_en = in_valid_i;
    dat_n  = inject_i ? marker_i : in_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= in_valid_i;
      if (dat_en) dat_q <= dat_n;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = dat_q;
endmodule

// File: rtl/lbt_timer_ctrl.sv
module lbt_timer_ctrl
  import lbt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          hit_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  lbt_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;
  logic          at_max;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    at_max = (cnt_q == CNT_MAX);
    cnt_en = arm_i || (st_q == ST_RUN);
    if (arm_i) begin
      st_n  = ST_RUN;
      cnt_n = '0;
    end else if (st_q == ST_RUN) begin
      if (hit_i) begin
        st_n  = ST_DONE;
        cnt_n = at_max ? cnt_q : cnt_q + 1'b1;
      end else if (at_max) begin
        st_n = ST_TOUT;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  assign busy_o    = (st_q == ST_RUN);
  assign done_o    = (st_q == ST_DONE);
  assign timeout_o = (st_q == ST_TOUT);
  assign count_o   = cnt_q;
endmodule

// File: rtl/lbt_latency_timer.sv
module lbt_latency_timer #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic [DW-1:0] fill_i,
  input  logic [DW-1:0] marker_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic [CW-1:0] count_o
);
  logic hit;
  logic running;

  lbt_match_detect #(.DW(DW)) u_match (
    .valid_i  (in_valid_i && running),
    .data_i   (in_data_i),
    .marker_i (marker_i),
    .fill_i   (fill_i),
    .hit_o    (hit)
  );

  lbt_timer_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm_i),
    .hit_i     (hit),
    .busy_o    (running),
    .done_o    (done_o),
    .timeout_o (timeout_o),
    .count_o   (count_o)
  );

  lbt_echo_path #(.DW(DW)) u_echo (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .inject_i    (running),
    .marker_i    (marker_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );

  assign busy_o = running;
endmodule

// File: rtl/lbt_latency_timer_chk.sv
module lbt_latency_timer_chk #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm_i,
  input logic [DW-1:0] fill_i,
  input logic [DW-1:0] marker_i,
  input logic          in_valid_i,
  input logic [DW-1:0] in_data_i,
  input logic          out_valid_o,
  input logic [DW-1:0] out_data_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          timeout_o,
  input logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic marker_seen;
  assign marker_seen = in_valid_i && (in_data_i == marker_i) && (in_data_i != fill_i);

  a_r2_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && in_valid_i) |=> (out_valid_o && out_data_o == $past(in_data_i)));

  a_r3_arm_starts: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (busy_o && count_o == '0 && !done_o && !timeout_o));

  a_r4_inject: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && in_valid_i) |=> (out_valid_o && out_data_o == $past(marker_i)));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !arm_i && count_o != CMAX) |=> (count_o == $past(count_o) + 1'b1));

  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !arm_i) |=> (done_o && $stable(count_o)));

  a_r7_no_false_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_i && !done_o && !(busy_o && marker_seen)) |=> !done_o);

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !arm_i) |=> (timeout_o && count_o == CMAX));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o) && !(busy_o && (done_o || timeout_o)));
endmodule

bind lbt_latency_timer lbt_latency_timer_chk #(.DW(DW), .CW(CW)) chk_i (.*);

// File: tb/lbt_latency_timer_tb.sv
module lbt_latency_timer_tb_top;
  localparam int DW = 32;
  localparam int CW = 10;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm_i = 1'b0;
  logic [DW-1:0] fill_i = 32'hF11F_F11F;
  logic [DW-1:0] marker_i = 32'hA5A5_0001;
  logic          in_valid_i = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic          out_valid_o;
  logic [DW-1:0] out_data_o;
  logic          busy_o, done_o, timeout_o;
  logic [CW-1:0] count_o;

  lbt_latency_timer #(.DW(DW), .CW(CW)) dut_i (.*);

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference model state
  bit          m_ov = 0;
  logic [DW-1:0] m_od = '0;
  bit          m_busy = 0, m_done = 0, m_to = 0;
  int          m_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ov = 0; m_od = '0; m_busy = 0; m_done = 0; m_to = 0; m_cnt = 0;
    end else begin
      m_ov = in_valid_i;
      if (in_valid_i) m_od = m_busy ? marker_i : in_data_i;
      if (arm_i) begin
        m_busy = 1; m_cnt = 0; m_done = 0; m_to = 0;
      end else if (m_busy) begin
        if (in_valid_i && in_data_i == marker_i && in_data_i != fill_i) begin
          m_busy = 0; m_done = 1;
          if (m_cnt < CMAX) m_cnt = m_cnt + 1;
        end else if (m_cnt == CMAX) begin
          m_busy = 0; m_to = 1;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stimulus control
  int  mode = 0;      // 0 idle data, 1 loop, 2 fill only, 3 non-marker words
  int  dly = 4;
  bit  gaps = 0;
  bit  arm_req = 0;
  bit  cmp_en = 0;
  logic [DW-1:0] hd [64];
  bit            hv [64];

  always @(negedge clk) begin
    cyc++;
    if (cmp_en) begin
      chk(out_valid_o == m_ov, "R2/R4 out_valid", out_valid_o, m_ov);
      chk(out_data_o == m_od, "R2/R4 out_data", out_data_o, m_od);
      chk(busy_o == m_busy, "R3 busy", busy_o, m_busy);
      chk(int'(count_o) == m_cnt, "R5 count", count_o, m_cnt);
      chk(done_o == m_done, "R6 done", done_o, m_done);
      chk(timeout_o == m_to, "R8 timeout", timeout_o, m_to);
    end
    hv[cyc % 64] = out_valid_o;
    hd[cyc % 64] = out_data_o;
    arm_i = arm_req;
    arm_req = 0;
    in_valid_i = gaps ? ((cyc % 5) != 3) : 1'b1;
    case (mode)
      0: in_data_i = (cyc % 7 == 0) ? marker_i : 32'h1000_0000 + cyc;
      1: begin
        if (cyc > dly && hv[(cyc - dly) % 64]) in_data_i = hd[(cyc - dly) % 64];
        else in_data_i = fill_i;
      end
      2: in_data_i = fill_i;
      default: in_data_i = (32'h2000_0000 + cyc * 3) ^ ((cyc % 2) ? fill_i : 32'h0);
    endcase
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic do_arm();
    @(posedge clk);
    arm_req = 1;
    @(posedge clk);
  endtask

  initial begin
    mode = 2;
    wait_cyc(3);
    #1;
    // R1: reset values
    chk(!out_valid_o && out_data_o == '0 && !busy_o && !done_o && !timeout_o && count_o == '0,
        "R1 reset", {busy_o, done_o, timeout_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(!busy_o && !done_o && count_o == '0, "R1 after release", count_o, 0);
    cmp_en = 1;

    // R2, R7: idle echo with marker values present but not armed
    mode = 0; gaps = 1;
    wait_cyc(40);
    #1;
    chk(!done_o && !busy_o, "R7 idle marker ignored", done_o, 0);

    // R6: closed loop, full valid, delay 5 -> count = delay + 2
    mode = 2; gaps = 0;
    wait_cyc(10);
    mode = 1; dly = 5;
    do_arm();
    wait_cyc(20);
    #1;
    chk(done_o == 1'b1, "R6 done set", done_o, 1);
    chk(int'(count_o) == dly + 2, "R6 count value", count_o, dly + 2);

    // R6: count holds after stop
    wait_cyc(8);
    #1;
    chk(int'(count_o) == dly + 2, "R6 count held", count_o, dly + 2);

    // R9: re-arm after done, loop with gaps and delay 17
    mode = 2;
    wait_cyc(30);
    mode = 1; dly = 17; gaps = 1;
    do_arm();
    #1;
    chk(busy_o && count_o == '0 && !done_o, "R9 rearm after done", count_o, 0);
    wait_cyc(40);
    #1;
    chk(done_o && !busy_o, "R6 gapped loop done", done_o, 1);

    // R7: non-marker traffic while armed never stops
    mode = 3; gaps = 1;
    do_arm();
    wait_cyc(60);
    #1;
    chk(busy_o && !done_o, "R7 non-marker no stop", done_o, 0);

    // R9: re-arm while running
    do_arm();
    #1;
    chk(busy_o && count_o == '0, "R9 rearm while busy", count_o, 0);

    // R8, R7: marker equal to fill, fill traffic only -> saturate
    mode = 2; gaps = 0;
    @(negedge clk);
    marker_i = fill_i;
    do_arm();
    wait_cyc(CMAX + 20);
    #1;
    chk(timeout_o && !done_o && int'(count_o) == CMAX, "R8 saturation", count_o, CMAX);
    chk(!(done_o && timeout_o) && !busy_o, "R10 exclusive flags", {done_o, timeout_o}, 2'b01);

    // R9: re-arm after timeout
    @(negedge clk);
    marker_i = 32'hA5A5_0002;
    do_arm();
    #1;
    chk(busy_o && !timeout_o && count_o == '0, "R9 rearm after timeout", count_o, 0);
    mode = 1; dly = 9;
    wait_cyc(30);
    #1;
    chk(done_o && !timeout_o && !busy_o, "R10 flags after stop", {busy_o, done_o, timeout_o}, 3'b010);

    wait_cyc(5);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule